// File: doc/BRIEF.md
# Dual-Law Serial Clock Divider

This block derives a serial clock for an SPI-style shift engine from a faster module clock. Two division laws feed the same output. The linear law divides by an even count, 2*(N+1), where N is an 8-bit field. The power-of-two law divides by 2^E, where E is a 4-bit exponent. A single select input picks the law. The linear law gives finer steps and is the usual choice. The power-of-two law reaches the very large ratios that the linear field cannot. The smallest ratio under either law is 2.

The output rests at the level given by the polarity input for as long as the enable input is low. Software can therefore program the law and both fields in any order without producing a stray pulse on the serial clock. Settings that change while the clock runs are taken up only at the start of the next period, so no high or low phase is ever cut short. Two strobes, each one module-clock cycle wide, mark the edge that leaves the idle level and the edge that returns to it. A shift engine uses them to launch and to capture data.

Top module: `sclk_divider`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sclk` equals `cpol` and both strobes are 0.
- R2: With `law_sel`=1 (linear law), each serial period lasts 2*(N+1) module cycles, where N is `lin_div`. The active phase and the idle phase each last N+1 cycles.
- R3: With `law_sel`=0 (power-of-two law) and 1 <= E <= EXP_MAX, where E is `pow_exp`, each period lasts 2^E module cycles. The two phases are equal.
- R4: With `law_sel`=0 and E=0, the output toggles on every module cycle, giving a period of 2. It is never a pass-through of the module clock.
- R5: An exponent above EXP_MAX behaves exactly like EXP_MAX.
- R6: While `bus_en` is 0, `sclk` equals `cpol` from the cycle after `bus_en` was seen low, and neither strobe is raised, whatever the law, fields and polarity are.
- R7: The idle level is `cpol`. The active phase drives `~cpol`, so with `cpol`=1 the leading edge falls.
- R8: The law and the fields are sampled only while the block is disabled and at each leading edge. A change made during a period leaves the remaining phases of that period unchanged and applies from the next leading edge.
- R9: `lead_stb` is high for exactly the one cycle in which `sclk` first shows the active level. `trail_stb` is high for the one cycle in which `sclk` is back at idle. Each occurs once per period and the two are never high together.
- R10: When `bus_en` is first seen high at a clock edge, with half-period H in effect, `sclk` leaves idle after the H-th edge counted from and including that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Runs the serial clock when 1; holds it idle when 0 |
| law_sel | input | 1 | 0: divide by 2^E; 1: divide by 2*(N+1) |
| pow_exp | input | EXP_W (4) | Exponent E for the power-of-two law |
| lin_div | input | LIN_W (8) | Field N for the linear law |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe with the edge leaving idle |
| trail_stb | output | 1 | One-cycle strobe with the edge returning to idle |

## Verification
The bench builds the block with the 8-bit linear field and the 4-bit exponent field at their default widths, but lowers EXP_MAX to 8. This keeps the longest power-of-two period at 256 cycles, so the whole exponent range, 0 to 15, can be swept. The sweep includes the seven values that must clamp. The linear field is swept from 0 to 20 and tested at 100 and at its maximum of 255, with both polarities. Further cases cover enable latency, settings changed in the middle of a period, and an idle period of many cycles.

// File: rtl/sclkdiv_pkg.sv
package sclkdiv_pkg;

  typedef enum logic {
    LAW_POW2 = 1'b0,
    LAW_LIN  = 1'b1
  } div_law_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sclkdiv_half_calc.sv
module sclkdiv_half_calc
  import sclkdiv_pkg::*;
#(
  parameter int unsigned LIN_W   = 8,
  parameter int unsigned EXP_W   = 4,
  parameter int unsigned EXP_MAX = 15,
  parameter int unsigned CNT_W   = 9
) (
  input  div_law_e         law,
  input  logic [LIN_W-1:0] lin_div,
  input  logic [EXP_W-1:0] pow_exp,
  output logic [CNT_W-1:0] half_len
);

  localparam int unsigned EXP_FIELD_MAX = (1 << EXP_W) - 1;

  logic [EXP_W-1:0] exp_eff;
  logic [CNT_W-1:0] pow_half;
  logic [CNT_W-1:0] lin_half;

  generate
    if (EXP_MAX >= EXP_FIELD_MAX) begin : g_no_clamp
      assign exp_eff = pow_exp;
    end else begin : g_clamp
      assign exp_eff = (32'(pow_exp) > EXP_MAX) ? EXP_W'(EXP_MAX) : pow_exp;
    end
  endgenerate

  always_comb begin
    if (exp_eff == '0) pow_half = CNT_W'(1);
    else               pow_half = CNT_W'(1) << (exp_eff - EXP_W'(1));
    lin_half = CNT_W'(lin_div) + CNT_W'(1);
    half_len = (law == LAW_LIN) ? lin_half : pow_half;
  end

endmodule

// File: rtl/sclkdiv_shadow.sv
module sclkdiv_shadow #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] half_in,
  output logic [CNT_W-1:0] half_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    half_q <= CNT_W'(1);
    else if (load) half_q <= half_in;
  end

  // R8: a held half length is never zero once loaded
  half_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_q != '0);

endmodule

// File: rtl/sclkdiv_half_ctr.sv
module sclkdiv_half_ctr #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] half_len,
  output logic             phase,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt;

  assign wrap = run && (cnt == half_len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt   <= cnt + CNT_W'(1);
    end
  end

  // R2: the phase counter never runs past the held half length
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < half_len));

endmodule

// File: rtl/sclk_divider.sv
module sclk_divider
  import sclkdiv_pkg::*;
#(
  parameter int unsigned LIN_W   = 8,
  parameter int unsigned EXP_W   = 4,
  parameter int unsigned EXP_MAX = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             law_sel,
  input  logic [EXP_W-1:0] pow_exp,
  input  logic [LIN_W-1:0] lin_div,
  input  logic             cpol,
  output logic             sclk,
  output logic             lead_stb,
  output logic             trail_stb
);

  localparam int unsigned CNT_W = max_u(LIN_W + 1, max_u(EXP_MAX, 1));

  div_law_e         law;
  logic [CNT_W-1:0] half_next;
  logic [CNT_W-1:0] half_held;
  logic             phase;
  logic             wrap;
  logic             load;
  logic             lead_q;
  logic             trail_q;

  assign law = div_law_e'(law_sel);

  sclkdiv_half_calc #(
    .LIN_W(LIN_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX), .CNT_W(CNT_W)
  ) u_calc (
    .law(law), .lin_div(lin_div), .pow_exp(pow_exp), .half_len(half_next)
  );

  // settings are taken while idle and at each leading edge only
  assign load = !bus_en || (wrap && !phase);

  sclkdiv_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load), .half_in(half_next), .half_q(half_held)
  );

  sclkdiv_half_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .run(bus_en), .half_len(half_held),
    .phase(phase), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      lead_q  <= wrap && !phase;
      trail_q <= wrap &&  phase;
    end
  end

  assign sclk      = cpol ^ phase;
  assign lead_stb  = lead_q;
  assign trail_stb = trail_q;

  // R6
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> (sclk == cpol) && !lead_stb && !trail_stb);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb && trail_stb));

  // R9
  lead_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |-> (sclk != cpol));

  // R9
  trail_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |-> (sclk == cpol));

  // R9
  edge_has_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_en) && bus_en && (phase != $past(phase))) |-> (lead_stb || trail_stb));

endmodule

// File: tb/test_sclk_divider.sv
module test_sclk_divider;

  localparam int CLK_PERIOD = 10;
  localparam int LIN_W      = 8;
  localparam int EXP_W      = 4;
  localparam int EXP_MAX    = 8;
  localparam int WAIT_LIM   = 2000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_en = 1'b0;
  logic             law_sel = 1'b1;
  logic [EXP_W-1:0] pow_exp = '0;
  logic [LIN_W-1:0] lin_div = '0;
  logic             cpol = 1'b0;
  logic             sclk, lead_stb, trail_stb;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sclk_divider #(.LIN_W(LIN_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX)) i_sclk_divider (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .law_sel(law_sel),
    .pow_exp(pow_exp), .lin_div(lin_div), .cpol(cpol),
    .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_stb(input bit want_lead, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(want_lead ? lead_stb : trail_stb) && n < WAIT_LIM);
  endtask

  function automatic int pow_half(input int e);
    int ee = (e > EXP_MAX) ? EXP_MAX : e;
    return (ee == 0) ? 1 : (1 << (ee - 1));
  endfunction

  task automatic run_case(input bit law, input int div, input int e, input bit pol,
                          input int h, input string req);
    int n;
    @(negedge clk);
    bus_en = 1'b0; law_sel = law; lin_div = LIN_W'(div); pow_exp = EXP_W'(e); cpol = pol;
    repeat (3) @(negedge clk);
    check(sclk == pol && !lead_stb && !trail_stb, "R6 idle before enable", sclk, pol);
    bus_en = 1'b1;
    wait_stb(1'b1, n);
    check(n == h, "R10 first leading edge latency", n, h);
    check(sclk == !pol, "R7 active level", sclk, !pol);
    wait_stb(1'b0, n);
    check(n == h, {req, " active phase"}, n, h);
    wait_stb(1'b1, n);
    check(n == h, {req, " idle phase"}, n, h);
    @(negedge clk);
    check(!lead_stb, "R9 lead strobe one cycle", lead_stb, 0);
    bus_en = 1'b0;
    @(negedge clk);
    check(sclk == pol && !lead_stb && !trail_stb, "R6 idle after disable", sclk, pol);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(sclk == cpol && !lead_stb && !trail_stb, "R1 reset state", sclk, cpol);
    rst_n = 1'b1;
    @(negedge clk);
    check(sclk == cpol && !lead_stb && !trail_stb, "R1 after reset", sclk, cpol);

    // R2 linear sweep, both polarities
    for (int d = 0; d <= 20; d++) run_case(1'b1, d, 0, d[0], d + 1, "R2");
    run_case(1'b1, 100, 3, 1'b0, 101, "R2");
    run_case(1'b1, 255, 3, 1'b1, 256, "R2");

    // R3 / R4 / R5 power-of-two sweep over the whole field
    for (int e = 0; e < 16; e++)
      run_case(1'b0, 7, e, e[1], pow_half(e),
               (e == 0) ? "R4" : ((e > EXP_MAX) ? "R5" : "R3"));

    // R6 long idle with changing settings and polarity
    @(negedge clk);
    bus_en = 1'b0; law_sel = 1'b1; lin_div = '0;
    for (int i = 0; i < 60; i++) begin
      cpol = i[2]; pow_exp = EXP_W'(i); law_sel = i[0];
      @(negedge clk);
      if (sclk != cpol || lead_stb || trail_stb)
        check(1'b0, "R6 held idle while disabled", sclk, cpol);
    end
    check(sclk == cpol, "R6 idle after sweep", sclk, cpol);

    // R8 change inside a period: linear 3 -> 1
    @(negedge clk);
    cpol = 1'b0; law_sel = 1'b1; lin_div = 8'd3;
    @(negedge clk);
    bus_en = 1'b1;
    wait_stb(1'b1, n);
    lin_div = 8'd1;
    wait_stb(1'b0, n);
    check(n == 4, "R8 active phase keeps old length", n, 4);
    wait_stb(1'b1, n);
    check(n == 4, "R8 idle phase keeps old length", n, 4);
    wait_stb(1'b0, n);
    check(n == 2, "R8 new length from next period", n, 2);

    // R8 law switch inside a period: linear 1 -> power exponent 4
    law_sel = 1'b0; pow_exp = 4'd4;
    wait_stb(1'b1, n);
    check(n == 2, "R8 idle phase before law switch", n, 2);
    wait_stb(1'b0, n);
    check(n == 8, "R8 law switch applied", n, 8);
    @(negedge clk);
    bus_en = 1'b0;
    @(negedge clk);
    check(sclk == cpol, "R6 disable mid-period", sclk, cpol);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule